// File: doc/BRIEF.md
# Data-Ready Acknowledge Aggregator

This block keeps track of which of four filter channels hold a result that nobody has read yet. Each channel signals a fresh result with a one-cycle pulse. If that channel's configuration allows acknowledgement, the pulse sets a sticky flag for the channel. A read strobe from the channel's data register clears the flag. The combined acknowledge pin stays asserted while at least one flag is set. A polarity input selects whether the asserted level of the pin is high or low.

The channel configuration is taken into account when a flag is set. A flag is never set in any of these cases: the channel's acknowledge enable is low, both of the channel's filter stages (sinc and integrator) are switched off, or both oversampling ratios equal one, which means no decimation. The flags are visible as a vector, so a host can see which channel produced the data.

Top module: `ack_aggregator`

## Requirements
- R1: During and right after synchronous reset, every flag is 0 and the pin sits at its inactive level, which equals `ack_pol_i`.
- R2: A `new_data_i[i]` pulse on a qualified channel sets `flags_o[i]` at the next rising clock edge.
- R3: A `rd_strobe_i[i]` pulse clears `flags_o[i]` at the next rising clock edge when no new data arrives on that channel in the same cycle.
- R4: If new data and a read occur on the same channel in the same cycle, the flag is 1 afterwards.
- R5: `ack_pin_o` is 1 when any flag is set and `ack_pol_i` is 0. When `ack_pol_i` is 1 the pin is inverted: it is 0 while any flag is set and 1 when no flag is set.
- R6: The pin stays active while any flag remains set and goes inactive only when all flags are 0.
- R7: A channel whose `ack_en_i[i]` is low does not get its flag set by new data.
- R8: A channel with both `sinc_en_i[i]` and `integ_en_i[i]` low does not get its flag set. One enabled stage is enough for the flag to set.
- R9: A channel whose sinc ratio and integrator ratio both equal 1 does not get its flag set. If only one of the two ratios is 1, the flag still sets. The ratio for channel i occupies bits [8i+7:8i] of `sinc_osr_i` and of `integ_osr_i`.
- R10: New data or a read on one channel leaves the flags of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| new_data_i | input | 4 | One-cycle new-result pulse per channel |
| rd_strobe_i | input | 4 | Data-register read strobe per channel |
| ack_en_i | input | 4 | Acknowledge enable per channel |
| sinc_en_i | input | 4 | Sinc stage enable per channel |
| integ_en_i | input | 4 | Integrator stage enable per channel |
| sinc_osr_i | input | 32 | Sinc oversampling ratio, 8 bits per channel |
| integ_osr_i | input | 32 | Integrator oversampling ratio, 8 bits per channel |
| ack_pol_i | input | 1 | Pin polarity: 1 inverts the pin |
| flags_o | output | 4 | Pending-data flag per channel |
| ack_pin_o | output | 1 | Combined acknowledge pin |

## Verification
The flag vector is a register output, so a wrong flag state shows at `flags_o` one clock edge after the pulse or strobe that caused it. Because the pin follows the flags without delay, the same error also shows at `ack_pin_o` in that cycle. A qualifier that decodes the wrong ratio slice, or that ignores an enable, leaves a flag set where the bench expects it clear, and the bench catches this on the next sample. A clear with the wrong priority shows up in the same-cycle set/read vector.

// File: rtl/ack_agg_pkg.sv
package ack_agg_pkg;

    localparam int OSR_W     = 8;
    localparam int OSR_UNITY = 1;

    typedef struct packed {
        logic             ack_en;
        logic             sinc_en;
        logic             integ_en;
        logic [OSR_W-1:0] sinc_osr;
        logic [OSR_W-1:0] integ_osr;
    } chan_cfg_t;

    // A flag may only be raised when acknowledging is enabled, at least one
    // filter stage runs, and at least one stage really decimates.
    function automatic logic cfg_permits_flag(input chan_cfg_t c);
        logic stage_on;
        logic no_decim;
        stage_on = c.sinc_en | c.integ_en;
        no_decim = (c.sinc_osr == OSR_W'(OSR_UNITY)) &&
                   (c.integ_osr == OSR_W'(OSR_UNITY));
        return c.ack_en & stage_on & ~no_decim;
    endfunction

endpackage

// File: rtl/ack_set_qualifier.sv
module ack_set_qualifier
    import ack_agg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] new_data_i,
    input  chan_cfg_t         cfg_i [NUM_CH],
    output logic [NUM_CH-1:0] set_o
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        always_comb begin
            set_o[i] = new_data_i[i] & cfg_permits_flag(cfg_i[i]);
        end
    end

endmodule

// File: rtl/ack_flag_bank.sv
module ack_flag_bank #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] set_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] flags_o
);

    logic [NUM_CH-1:0] flag_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
        // set wins over clear so a result arriving during a read is kept
        always_ff @(posedge clk) begin
            if (rst)           flag_q[i] <= 1'b0;
            else if (set_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i[i]) flag_q[i] <= 1'b0;
        end

        p_set_r2: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flag_q[i]);

        p_clear_r3: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !flag_q[i]);

        p_set_beats_read_r4: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && set_i[i]) |=> flag_q[i]);

        p_hold_r10: assert property (@(posedge clk) disable iff (rst)
            (!clr_i[i] && !set_i[i]) |=> $stable(flag_q[i]));
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (flag_q == '0));

    assign flags_o = flag_q;

endmodule

// File: rtl/ack_pin_driver.sv
module ack_pin_driver #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] flags_i,
    input  logic              pol_i,
    output logic              pin_o
);

    logic any_pending;

    always_comb begin
        any_pending = |flags_i;
        pin_o       = any_pending ^ pol_i;
    end

endmodule

// File: rtl/ack_aggregator.sv
module ack_aggregator
    import ack_agg_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int OSR_BUS_W = NUM_CH * OSR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CH-1:0]    new_data_i,
    input  logic [NUM_CH-1:0]    rd_strobe_i,
    input  logic [NUM_CH-1:0]    ack_en_i,
    input  logic [NUM_CH-1:0]    sinc_en_i,
    input  logic [NUM_CH-1:0]    integ_en_i,
    input  logic [OSR_BUS_W-1:0] sinc_osr_i,
    input  logic [OSR_BUS_W-1:0] integ_osr_i,
    input  logic                 ack_pol_i,
    output logic [NUM_CH-1:0]    flags_o,
    output logic                 ack_pin_o
);

    chan_cfg_t         cfg [NUM_CH];
    logic [NUM_CH-1:0] set_req;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_cfg
        always_comb begin
            cfg[i].ack_en    = ack_en_i[i];
            cfg[i].sinc_en   = sinc_en_i[i];
            cfg[i].integ_en  = integ_en_i[i];
            cfg[i].sinc_osr  = sinc_osr_i[i*OSR_W +: OSR_W];
            cfg[i].integ_osr = integ_osr_i[i*OSR_W +: OSR_W];
        end

        p_ack_off_r7: assert property (@(posedge clk) disable iff (rst)
            (!ack_en_i[i] && !flags_o[i]) |=> !flags_o[i]);

        p_stages_off_r8: assert property (@(posedge clk) disable iff (rst)
            (!sinc_en_i[i] && !integ_en_i[i] && !flags_o[i]) |=> !flags_o[i]);

        p_unity_osr_r9: assert property (@(posedge clk) disable iff (rst)
            ((sinc_osr_i[i*OSR_W +: OSR_W] == OSR_W'(OSR_UNITY)) &&
             (integ_osr_i[i*OSR_W +: OSR_W] == OSR_W'(OSR_UNITY)) &&
             !flags_o[i]) |=> !flags_o[i]);
    end

    ack_set_qualifier #(.NUM_CH(NUM_CH)) u_qual (
        .new_data_i (new_data_i),
        .cfg_i      (cfg),
        .set_o      (set_req)
    );

    ack_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_req),
        .clr_i   (rd_strobe_i),
        .flags_o (flags_o)
    );

    ack_pin_driver #(.NUM_CH(NUM_CH)) u_pin (
        .flags_i (flags_o),
        .pol_i   (ack_pol_i),
        .pin_o   (ack_pin_o)
    );

    p_pin_level_r5: assert property (@(posedge clk) disable iff (rst)
        ack_pin_o == ((flags_o != '0) ^ ack_pol_i));

    p_pin_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (flags_o == '0) |-> (ack_pin_o == ack_pol_i));

endmodule

// File: tb/ack_aggregator_tb.sv
module ack_aggregator_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int NVEC       = 15;

    typedef struct packed {
        logic [3:0]  nd;
        logic [3:0]  rd;
        logic [3:0]  aen;
        logic [3:0]  sen;
        logic [3:0]  ien;
        logic [31:0] sosr;
        logic [31:0] iosr;
        logic        pol;
        logic [3:0]  exp_flags;
        logic        exp_pin;
        logic [23:0] tag;
    } vec_t;

    localparam logic [31:0] SO = 32'h40404040;
    localparam logic [31:0] IO = 32'h01010101;

    localparam vec_t VECS [NVEC] = '{
        // R2: set ch0
        '{nd:4'b0001, rd:4'b0000, aen:4'hF, sen:4'hF, ien:4'hF, sosr:SO, iosr:IO, pol:1'b0, exp_flags:4'b0001, exp_pin:1'b1, tag:"R2 "},
        // R10: set ch2, ch0 kept
        '{nd:4'b0100, rd:4'b0000, aen:4'hF, sen:4'hF, ien:4'hF, sosr:SO, iosr:IO, pol:1'b0, exp_flags:4'b0101, exp_pin:1'b1, tag:"R10"},
        // R6: read ch0, pin stays active
        '{nd:4'b0000, rd:4'b0001, aen:4'hF, sen:4'hF, ien:4'hF, sosr:SO, iosr:IO, pol:1'b0, exp_flags:4'b0100, exp_pin:1'b1, tag:"R6 "},
        // R4: same-cycle set and read on ch1
        '{nd:4'b0010, rd:4'b0010, aen:4'hF, sen:4'hF, ien:4'hF, sosr:SO, iosr:IO, pol:1'b0, exp_flags:4'b0110, exp_pin:1'b1, tag:"R4 "},
        // R3: read both remaining
        '{nd:4'b0000, rd:4'b0110, aen:4'hF, sen:4'hF, ien:4'hF, sosr:SO, iosr:IO, pol:1'b0, exp_flags:4'b0000, exp_pin:1'b0, tag:"R3 "},
        // R5: inverted idle level
        '{nd:4'b0000, rd:4'b0000, aen:4'hF, sen:4'hF, ien:4'hF, sosr:SO, iosr:IO, pol:1'b1, exp_flags:4'b0000, exp_pin:1'b1, tag:"R5 "},
        // R5: inverted active level
        '{nd:4'b1000, rd:4'b0000, aen:4'hF, sen:4'hF, ien:4'hF, sosr:SO, iosr:IO, pol:1'b1, exp_flags:4'b1000, exp_pin:1'b0, tag:"R5 "},
        // R7: ch0 acknowledge disabled
        '{nd:4'b0001, rd:4'b0000, aen:4'hE, sen:4'hF, ien:4'hF, sosr:SO, iosr:IO, pol:1'b1, exp_flags:4'b1000, exp_pin:1'b0, tag:"R7 "},
        // R8: ch0 both stages off
        '{nd:4'b0001, rd:4'b0000, aen:4'hF, sen:4'hE, ien:4'hE, sosr:SO, iosr:IO, pol:1'b1, exp_flags:4'b1000, exp_pin:1'b0, tag:"R8 "},
        // R8: ch0 sinc only is enough
        '{nd:4'b0001, rd:4'b0000, aen:4'hF, sen:4'hF, ien:4'hE, sosr:SO, iosr:IO, pol:1'b1, exp_flags:4'b1001, exp_pin:1'b0, tag:"R8 "},
        // R3: clear all
        '{nd:4'b0000, rd:4'b1001, aen:4'hF, sen:4'hF, ien:4'hF, sosr:SO, iosr:IO, pol:1'b0, exp_flags:4'b0000, exp_pin:1'b0, tag:"R3 "},
        // R9: ch0 both ratios 1
        '{nd:4'b0001, rd:4'b0000, aen:4'hF, sen:4'hF, ien:4'hF, sosr:32'h40404001, iosr:IO, pol:1'b0, exp_flags:4'b0000, exp_pin:1'b0, tag:"R9 "},
        // R9: ch0 sinc 1 but integrator decimates
        '{nd:4'b0001, rd:4'b0000, aen:4'hF, sen:4'hF, ien:4'hF, sosr:32'h40404001, iosr:32'h01010140, pol:1'b0, exp_flags:4'b0001, exp_pin:1'b1, tag:"R9 "},
        // R9: ch3 field in top byte both 1
        '{nd:4'b1111, rd:4'b0000, aen:4'hF, sen:4'hF, ien:4'hF, sosr:32'h01404040, iosr:IO, pol:1'b0, exp_flags:4'b0111, exp_pin:1'b1, tag:"R9 "},
        // R6: all cleared, pin idle
        '{nd:4'b0000, rd:4'b1111, aen:4'hF, sen:4'hF, ien:4'hF, sosr:SO, iosr:IO, pol:1'b0, exp_flags:4'b0000, exp_pin:1'b0, tag:"R6 "}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  new_data, rd_strobe, ack_en, sinc_en, integ_en;
    logic [31:0] sinc_osr, integ_osr;
    logic        ack_pol;
    logic [3:0]  flags;
    logic        ack_pin;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ack_aggregator #(.NUM_CH(NCH)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .new_data_i  (new_data),
        .rd_strobe_i (rd_strobe),
        .ack_en_i    (ack_en),
        .sinc_en_i   (sinc_en),
        .integ_en_i  (integ_en),
        .sinc_osr_i  (sinc_osr),
        .integ_osr_i (integ_osr),
        .ack_pol_i   (ack_pol),
        .flags_o     (flags),
        .ack_pin_o   (ack_pin)
    );

    task automatic check(input string tag, input logic [3:0] ef, input logic ep);
        checks++;
        if (flags !== ef || ack_pin !== ep) begin
            errors++;
            $display("FAIL %s: flags=%b pin=%b expected flags=%b pin=%b",
                     tag, flags, ack_pin, ef, ep);
        end
    endtask

    task automatic drive_idle();
        new_data  = '0;
        rd_strobe = '0;
        ack_en    = 4'hF;
        sinc_en   = 4'hF;
        integ_en  = 4'hF;
        sinc_osr  = SO;
        integ_osr = IO;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        drive_idle();
        rst     = 1'b1;
        ack_pol = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 4'b0000, 1'b1);   // reset, inverted polarity idle
        ack_pol = 1'b0;
        rst     = 1'b0;
        @(negedge clk);
        check("R1", 4'b0000, 1'b0);

        for (int v = 0; v < NVEC; v++) begin
            new_data  = VECS[v].nd;
            rd_strobe = VECS[v].rd;
            ack_en    = VECS[v].aen;
            sinc_en   = VECS[v].sen;
            integ_en  = VECS[v].ien;
            sinc_osr  = VECS[v].sosr;
            integ_osr = VECS[v].iosr;
            ack_pol   = VECS[v].pol;
            @(posedge clk);
            @(negedge clk);
            drive_idle();
            check(string'(VECS[v].tag), VECS[v].exp_flags, VECS[v].exp_pin);
        end

        // R1: reset in the middle of operation clears pending flags
        new_data = 4'b1010;
        @(negedge clk);
        new_data = '0;
        check("R2", 4'b1010, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R1", 4'b0000, 1'b0);
        rst = 1'b0;

        // R10: flag holds over idle cycles
        new_data = 4'b0100;
        @(negedge clk);
        new_data = '0;
        repeat (3) @(negedge clk);
        check("R10", 4'b0100, 1'b1);

        // R3: reading a channel without a flag leaves others untouched
        rd_strobe = 4'b1011;
        @(negedge clk);
        rd_strobe = '0;
        check("R3", 4'b0100, 1'b1);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule